// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This unit draws a 32x32 hardware cursor on top of a stream of background pixels. The cursor image is held in a local bitmap RAM. Each bitmap word is 16 bits and can do one of three things to the pixel under it: leave the background as it is, replace it with a fixed RGB15 colour, or XOR-invert it with a colour mask. A host write port loads the bitmap, a staged cursor position and a staged enable.

The display pipeline sends raster coordinates with a valid strobe, together with the RGB15 background pixel at that point. For each such pixel the unit decides whether the raster point lies inside the live cursor window and inside the active display area. When it does, the unit mixes in the cursor word for that point. The mixed pixel comes out two cycles later.

Position and enable changes are held in a staging register. They reach the live state only during vertical retrace, so the cursor never tears in the middle of a frame.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid and out_pix are 0, and the cursor is disabled, so every pixel passes its background through unchanged.
- R2: Each cycle with pix_valid high produces exactly one cycle of out_valid high, two clock cycles later. out_valid stays low otherwise.
- R3: A host write with host_sel = 0 stores host_wdata[15:0] at bitmap index host_addr. Cursor-relative pixel (cx, cy) uses index cx + 32*cy.
- R4: A cursor word of 0x0000 is transparent. The output equals the background.
- R5: A cursor word with bit 15 set is opaque. The output equals bits 14:0 of the word (0x8000 gives black, 0xFFFF gives white).
- R6: A cursor word with bit 15 clear and a nonzero value outputs the background XOR bits 14:0 of the word.
- R7: A host write with host_sel = 1 stages the cursor position: x from host_wdata[11:0] and y from host_wdata[27:16]; the other bits are ignored. The cursor covers raster x from X to X+31 and raster y from Y to Y+31. Raster points outside that window pass the background through.
- R8: A staged position becomes live only at the clock edge that samples vretrace high. Pixels before that edge still use the old live position.
- R9: A host write with host_sel = 2 stages the enable from host_wdata[0]. It becomes live only together with a pending position, at retrace. A retrace with no staged position leaves the live enable unchanged.
- R10: Raster points with ras_x >= 640 or ras_y >= 480 (the active-area parameters) pass the background through, even inside the cursor window.
- R11: While the live enable is 0, every pixel passes its background through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Write target: 0 bitmap, 1 position, 2 enable, 3 ignored |
| host_addr | input | 10 | Bitmap index for bitmap writes |
| host_wdata | input | 32 | Host write data |
| vretrace | input | 1 | Vertical retrace; commits a staged update |
| pix_valid | input | 1 | Raster coordinate and background are valid |
| ras_x | input | 12 | Raster x coordinate |
| ras_y | input | 12 | Raster y coordinate |
| bg_pix | input | 15 | Background RGB15 pixel |
| out_valid | output | 1 | Mixed pixel valid |
| out_pix | output | 15 | Mixed RGB15 pixel |

## Verification
The assertions assume that vretrace and host position writes do not land in the same cycle. They also assume that bitmap writes never target a word being read for a pixel in flight, since read-during-write order is left to the RAM inference. The stimulus loads the whole bitmap before any cursor is enabled. It separates each host write and retrace pulse from the pixel bursts, and it drives every input at the falling edge. The raster sweeps run past every edge of the cursor window and past the active-area limits.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int PIX_W  = 15;
  localparam int WORD_W = 16;
  localparam int HOST_W = 32;
  localparam int POS_Y_LSB = 16;

  typedef enum logic [1:0] {
    SEL_BITMAP = 2'd0,
    SEL_POS    = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } host_sel_e;

  // Mode is encoded in the cursor word itself: zero = see-through,
  // top bit = paint colour, otherwise = XOR mask.
  function automatic logic [PIX_W-1:0] mix_pixel(input logic [WORD_W-1:0] cur,
                                                 input logic [PIX_W-1:0]  bg);
    logic [PIX_W-1:0] res;
    if (cur == '0)                res = bg;
    else if (cur[WORD_W-1])       res = cur[PIX_W-1:0];
    else                          res = bg ^ cur[PIX_W-1:0];
    return res;
  endfunction

endpackage

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cursor_pos_regs.sv
module cursor_pos_regs #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pos_we,
  input  logic [CW-1:0] pos_x,
  input  logic [CW-1:0] pos_y,
  input  logic          ctrl_we,
  input  logic          ctrl_en,
  input  logic          vretrace,
  output logic [CW-1:0] live_x,
  output logic [CW-1:0] live_y,
  output logic          live_en
);

  logic [CW-1:0] stg_x, stg_y;
  logic          stg_en;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_x   <= '0;
      stg_y   <= '0;
      stg_en  <= 1'b0;
      pend    <= 1'b0;
      live_x  <= '0;
      live_y  <= '0;
      live_en <= 1'b0;
    end else begin
      if (vretrace && pend) begin
        live_x  <= stg_x;
        live_y  <= stg_y;
        live_en <= stg_en;
        pend    <= 1'b0;
      end
      if (pos_we) begin
        stg_x <= pos_x;
        stg_y <= pos_y;
        pend  <= 1'b1;
      end
      if (ctrl_we) stg_en <= ctrl_en;
    end
  end

  // R8: live position only moves on an edge that saw retrace
  a_r8_pos_at_retrace: assert property (@(posedge clk) disable iff (rst)
    ((live_x != $past(live_x)) || (live_y != $past(live_y))) |-> $past(vretrace));

  // R9: live enable only moves on an edge that saw retrace
  a_r9_en_at_retrace: assert property (@(posedge clk) disable iff (rst)
    (live_en != $past(live_en)) |-> $past(vretrace));

  // R8: a pending update is committed with the staged values
  a_r8_commit_value: assert property (@(posedge clk) disable iff (rst)
    ($past(vretrace) && $past(pend) && !$past(rst)) |->
      (live_x == $past(stg_x) && live_y == $past(stg_y) && live_en == $past(stg_en)));

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
  parameter int CW    = 12,
  parameter int DIM   = 32,
  parameter int ACT_W = 640,
  parameter int ACT_H = 480,
  parameter int AW    = 2 * $clog2(DIM)
) (
  input  logic [CW-1:0] ras_x,
  input  logic [CW-1:0] ras_y,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic          cur_en,
  output logic          hit,
  output logic [AW-1:0] addr
);

  localparam int DL = AW / 2;
  localparam logic [CW:0]   DIM_C   = (CW+1)'(DIM);
  localparam logic [CW-1:0] ACT_W_C = CW'(ACT_W);
  localparam logic [CW-1:0] ACT_H_C = CW'(ACT_H);

  logic [CW:0] dx, dy;
  logic        in_x, in_y, in_act;

  assign dx     = {1'b0, ras_x} - {1'b0, cur_x};
  assign dy     = {1'b0, ras_y} - {1'b0, cur_y};
  assign in_x   = (ras_x >= cur_x) && (dx < DIM_C);
  assign in_y   = (ras_y >= cur_y) && (dy < DIM_C);
  assign in_act = (ras_x < ACT_W_C) && (ras_y < ACT_H_C);
  assign hit    = cur_en && in_x && in_y && in_act;
  // row-major: index = column + DIM * row
  assign addr   = {dy[DL-1:0], dx[DL-1:0]};

endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
  import cursor_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_bg,
  input  logic              in_hit,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);

  // stage 1 waits alongside the RAM read
  logic             v1, hit1;
  logic [PIX_W-1:0] bg1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      hit1 <= 1'b0;
      bg1  <= '0;
    end else begin
      v1   <= in_valid;
      hit1 <= in_valid && in_hit;
      bg1  <= in_bg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_pix <= hit1 ? mix_pixel(ram_rdata, bg1) : bg1;
    end
  end

  // R4: transparent word keeps the background
  a_r4_transparent: assert property (@(posedge clk) disable iff (rst)
    (v1 && hit1 && ram_rdata == '0) |=> (out_pix == $past(bg1)));

  // R5: opaque word paints its colour
  a_r5_opaque: assert property (@(posedge clk) disable iff (rst)
    (v1 && hit1 && ram_rdata[WORD_W-1]) |=> (out_pix == $past(ram_rdata[PIX_W-1:0])));

  // R6: XOR word inverts the background
  a_r6_xor: assert property (@(posedge clk) disable iff (rst)
    (v1 && hit1 && !ram_rdata[WORD_W-1] && ram_rdata != '0) |=>
      (out_pix == ($past(bg1) ^ $past(ram_rdata[PIX_W-1:0]))));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CUR_DIM = 32,
  parameter int ACT_W   = 640,
  parameter int ACT_H   = 480,
  parameter int ADDR_W  = 2 * $clog2(CUR_DIM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [1:0]         host_sel,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HOST_W-1:0]  host_wdata,
  input  logic               vretrace,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] ras_x,
  input  logic [COORD_W-1:0] ras_y,
  input  logic [PIX_W-1:0]   bg_pix,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix
);

  localparam int DEPTH = CUR_DIM * CUR_DIM;
  localparam logic [COORD_W-1:0] ACT_W_C = COORD_W'(ACT_W);
  localparam logic [COORD_W-1:0] ACT_H_C = COORD_W'(ACT_H);

  logic               wr_bmp, wr_pos, wr_ctl;
  logic [COORD_W-1:0] live_x, live_y;
  logic               live_en;
  logic               hit;
  logic [ADDR_W-1:0]  rd_addr;
  logic [WORD_W-1:0]  rd_data;
  logic               unused_bits;

  assign wr_bmp = host_we && (host_sel == SEL_BITMAP);
  assign wr_pos = host_we && (host_sel == SEL_POS);
  assign wr_ctl = host_we && (host_sel == SEL_CTRL);
  assign unused_bits = ^{host_wdata[HOST_W-1:POS_Y_LSB+COORD_W],
                         host_wdata[POS_Y_LSB-1:COORD_W]};

  cursor_bitmap_ram #(.DEPTH(DEPTH), .DW(WORD_W), .AW(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_bmp),
    .waddr (host_addr),
    .wdata (host_wdata[WORD_W-1:0]),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  cursor_pos_regs #(.CW(COORD_W)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .pos_we  (wr_pos),
    .pos_x   (host_wdata[COORD_W-1:0]),
    .pos_y   (host_wdata[POS_Y_LSB+COORD_W-1:POS_Y_LSB]),
    .ctrl_we (wr_ctl),
    .ctrl_en (host_wdata[0]),
    .vretrace(vretrace),
    .live_x  (live_x),
    .live_y  (live_y),
    .live_en (live_en)
  );

  cursor_hit #(.CW(COORD_W), .DIM(CUR_DIM), .ACT_W(ACT_W), .ACT_H(ACT_H),
               .AW(ADDR_W)) u_hit (
    .ras_x  (ras_x),
    .ras_y  (ras_y),
    .cur_x  (live_x),
    .cur_y  (live_y),
    .cur_en (live_en),
    .hit    (hit),
    .addr   (rd_addr)
  );

  cursor_mixer u_mix (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (pix_valid),
    .in_bg     (bg_pix),
    .in_hit    (hit),
    .ram_rdata (rd_data),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

  // R2: two-cycle latency, one output per input
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ##2 out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> ##2 !out_valid);

  // R10: outside the active area the background passes
  a_r10_clip: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (ras_x >= ACT_W_C || ras_y >= ACT_H_C)) |-> ##2 (out_pix == $past(bg_pix, 2)));

  // R11: disabled cursor is invisible
  a_r11_disabled: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !live_en) |-> ##2 (out_pix == $past(bg_pix, 2)));

endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;

  localparam int ACT_W = 640;
  localparam int ACT_H = 480;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd3;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        vretrace = 1'b0;
  logic        pix_valid = 1'b0;
  logic [11:0] ras_x = '0;
  logic [11:0] ras_y = '0;
  logic [14:0] bg_pix = '0;
  logic        out_valid;
  logic [14:0] out_pix;

  always #2 clk = ~clk;

  cursor_overlay dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .vretrace(vretrace),
    .pix_valid(pix_valid), .ras_x(ras_x), .ras_y(ras_y), .bg_pix(bg_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [14:0] exp_q[$];
  string       tag_q[$];

  // bench-side reference state
  logic [15:0] bmp [1024];
  int  m_x = 0, m_y = 0, s_x = 0, s_y = 0;
  bit  m_en = 0, s_en = 0, s_pend = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(int x, int y);
    return m_en && x >= m_x && x < m_x + 32 && y >= m_y && y < m_y + 32 &&
           x < ACT_W && y < ACT_H;
  endfunction

  task automatic drive_pix(int x, int y, logic [14:0] bg);
    logic [15:0] c;
    logic [14:0] e;
    string t;
    @(negedge clk);
    host_we = 1'b0; vretrace = 1'b0;
    pix_valid = 1'b1; ras_x = 12'(x); ras_y = 12'(y); bg_pix = bg;
    if (!model_hit(x, y)) begin
      e = bg;
      if (!m_en) t = "R11";
      else if (x >= ACT_W || y >= ACT_H) t = "R10";
      else t = "R7";
    end else begin
      c = bmp[(x - m_x) + 32 * (y - m_y)];
      if (c == 16'h0)   begin e = bg;           t = "R4/R3"; end
      else if (c[15])   begin e = c[14:0];      t = "R5/R3"; end
      else              begin e = bg ^ c[14:0]; t = "R6/R3"; end
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b0; host_we = 1'b0; vretrace = 1'b0;
    end
  endtask

  task automatic host_wr(logic [1:0] sel, logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    pix_valid = 1'b0; vretrace = 1'b0;
    host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
    if (sel == 2'd0) bmp[a] = d[15:0];
    if (sel == 2'd1) begin s_x = int'(d[11:0]); s_y = int'(d[27:16]); s_pend = 1; end
    if (sel == 2'd2) s_en = d[0];
    @(negedge clk);
    host_we = 1'b0; host_sel = 2'd3;
  endtask

  task automatic retrace();
    @(negedge clk);
    pix_valid = 1'b0; host_we = 1'b0; vretrace = 1'b1;
    if (s_pend) begin m_x = s_x; m_y = s_y; m_en = s_en; s_pend = 0; end
    @(negedge clk);
    vretrace = 1'b0;
  endtask

  function automatic logic [15:0] pattern(int i);
    case (i % 4)
      0: return 16'h0000;
      1: return 16'h8000 | 16'((i * 37) & 16'h7fff);
      2: return 16'((i * 53) & 16'h7fff) | 16'h0001;
      default: return ((i % 8) == 3) ? 16'hffff : 16'h7fff;
    endcase
  endfunction

  function automatic logic [14:0] bgval(int x, int y);
    return 15'((x * 7 + y * 131 + 5) & 15'h7fff);
  endfunction

  task automatic sweep(int x0, int x1, int y0, int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        drive_pix(x, y, bgval(x, y));
    idle(3);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected out_valid", 1, 0);
      else begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_pix == e, t, int'(out_pix), int'(e));
      end
    end
  end

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_pix == 15'h0, "R1 out_pix", int'(out_pix), 0);

    // R3: load the bitmap
    for (int i = 0; i < 1024; i++) host_wr(2'd0, 10'(i), {16'hdead, pattern(i)});

    // R1/R11: cursor disabled after reset
    sweep(0, 40, 0, 40);

    // R2: single pixel latency
    drive_pix(5, 5, 15'h1234);
    @(negedge clk); pix_valid = 1'b0;
    check(out_valid == 1'b0, "R2 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 on time", int'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 single", int'(out_valid), 0);

    // R7/R9: enable and position with junk in ignored bits
    host_wr(2'd2, '0, 32'h0000_0001);
    host_wr(2'd1, '0, {4'hf, 12'd50, 4'ha, 12'd100});
    // R8: not live before retrace
    sweep(98, 104, 48, 52);
    retrace();
    sweep(97, 133, 48, 83);

    // R9: enable off without a new position has no effect at retrace
    host_wr(2'd2, '0, 32'h0);
    retrace();
    sweep(99, 110, 49, 55);
    // R9: next position commit carries the disable
    host_wr(2'd1, '0, {4'h0, 12'd10, 4'h0, 12'd200});
    retrace();
    sweep(198, 206, 8, 14);
    sweep(100, 106, 50, 54);

    // R10: cursor straddling the active-area corner
    host_wr(2'd2, '0, 32'h1);
    host_wr(2'd1, '0, {4'h0, 12'd470, 4'h0, 12'd620});
    retrace();
    sweep(615, 655, 465, 505);

    idle(5);
    check(exp_q.size() == 0, "R2 outstanding", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule